// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line-Fill Buffer

This block is a read-only instruction cache. It sits between a processor's fetch port and an external memory that answers in bursts. It stores 1 KB of code as 64 direct-mapped lines of 16 bytes. Each line has one tag and one valid bit. Next to the main arrays sits a one-line fill buffer, which keeps a valid flag for each 32-bit word. Every fetch looks up the main arrays and the fill buffer at the same time. A hit in either one is acknowledged in the cycle the request is presented, and the data is returned in that same cycle.

When both lookups miss, the cache asks external memory for the whole 16-byte line. The words return in ascending order into the fill buffer. A fetch can be served from the buffer as soon as its own word has arrived, so the fetch port is free again while the rest of the line is still loading. When all four words are present, the line is written into the main arrays in a single cycle. A miss to a different line that arrives during a fill waits until that fill has been written. A level input, `cache_en`, switches the main array in and out of use. The fill buffer is always consulted.

Top module: `icache_top`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears every tag valid bit and every fill-buffer word flag. After reset, `mem_req` is low and the first fetch is not acknowledged in its first cycle.
- R2: With `cache_en` high, a fetch to a resident line sets `fetch_ack` in the same cycle as `fetch_req`. Address bits 9:4 select the line, bits 3:2 select the 32-bit word, and bits 31:10 are compared with the stored tag. Bits 1:0 are ignored.
- R3: A line is written into the main arrays only when all four of its words are present, and the tag and valid bit are written in the same cycle. After the fill buffer has moved on to another line, the line still hits.
- R4: A fetch whose word is already present in the fill buffer is acknowledged in its first cycle, even while later words of that line are still outstanding.
- R5: On a miss in both lookups, `mem_req` rises with `mem_addr` set to the line address (bits 3:0 zero). `mem_req` and `mem_addr` hold steady until `mem_gnt`. Four beats then follow, each marked by `mem_rvalid`, carrying words 0, 1, 2, 3 of the line in that order.
- R6: Once the word that caused a miss has been delivered, fetches that hit the main array are acknowledged at once while the burst continues.
- R7: A miss to a different line during an ongoing fill gets no acknowledgement and no new burst until the current line has been written. Only then is its own burst issued.
- R8: With `cache_en` low, the main array never produces a hit. A fetch to a resident line starts a burst, while fill-buffer hits still complete in one cycle.
- R9: Two addresses that share bits 9:4 but differ in bits 31:10 occupy the same line. Filling one of them evicts the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cache_en | input | 1 | Enables hits from the main array |
| fetch_req | input | 1 | Fetch request, held until acknowledged |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ack | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Instruction word, valid with fetch_ack |
| mem_req | output | 1 | Burst read request |
| mem_gnt | input | 1 | Memory accepts the burst request |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_rvalid | input | 1 | Burst data beat valid |
| mem_rdata | input | 32 | Burst data beat |

## Verification
The assertions check four behaviours on every cycle. The burst request and its address stay stable until granted. The fill-buffer word flags only ever fill from word 0 upward. The arrays are written only with a complete line and end up holding that tag as valid. No acknowledgement comes from the main array while it is disabled. The bench scenarios are needed for the timing relations that span several requests. These are: a partly filled line serving early, hits from the array going through during a burst, a second miss stalling until the first line is written, and a conflicting line evicting its neighbour.

// File: rtl/icache_pkg.sv
// Package: shared types for the instruction cache.
// Assumes: nothing beyond IEEE 1800-2017.
package icache_pkg;
    // Fill sequencer states.
    typedef enum logic [1:0] {
        FB_IDLE  = 2'd0,   // no burst outstanding
        FB_REQ   = 2'd1,   // request raised, waiting for grant
        FB_FILL  = 2'd2,   // collecting beats
        FB_WRITE = 2'd3    // copying the complete line into the arrays
    } fb_state_t;
endpackage

// File: rtl/icache_tags.sv
// Module: tag and valid storage, one entry per line, read combinationally.
// Assumes: one write port, driven only with a complete line's tag; the tag
// contents need no reset because the valid bits guard them.
module icache_tags #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             tag_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tags_q [LINES];

    // Valid bits: cleared by reset, set when a line is installed.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // Tag storage: overwritten when a line is installed.
    always_ff @(posedge clk) begin
        if (wr_en) tags_q[wr_idx] <= wr_tag;
    end

    // Lookup: the entry is valid and its stored tag matches.
    always_comb tag_hit = valid_q[rd_idx] && (tags_q[rd_idx] == rd_tag);

    // An install leaves the entry valid with the new tag (R3).
    p_install_sets_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)] && (tags_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/icache_data.sv
// Module: instruction data array, LINES x LINE_WORDS words, async read.
// Assumes: writes always cover a whole line in one cycle.
module icache_data #(
    parameter int LINES      = 64,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 6,
    parameter int WSEL_W     = 2
) (
    input  logic                         clk,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [WSEL_W-1:0]            rd_wsel,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [LINE_WORDS*DATA_W-1:0] wr_line
);
    logic [DATA_W-1:0] mem_q [LINES][LINE_WORDS];

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        // Word lane w: stores its slice of an installed line.
        always_ff @(posedge clk) begin
            if (wr_en) mem_q[wr_idx][w] <= wr_line[w*DATA_W +: DATA_W];
        end
    end

    // Read port: selected word of the indexed line.
    always_comb rd_data = mem_q[rd_idx][rd_wsel];
endmodule

// File: rtl/icache_fill.sv
// Module: line-fill buffer and burst sequencer.
// Holds one line with a valid flag per word, issues the burst, captures the
// beats in ascending order and hands the complete line to the arrays.
// Assumes: memory returns exactly LINE_WORDS beats per granted request,
// word 0 first; a new fill starts only from idle.
module icache_fill
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_AW    = 28,
    parameter int WSEL_W     = 2,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         need_fill,
    input  logic [LINE_AW-1:0]           lk_line,
    input  logic [WSEL_W-1:0]            lk_wsel,
    output logic                         fb_hit,
    output logic [DATA_W-1:0]            fb_data,
    output logic                         busy,
    output logic                         mem_req,
    input  logic                         mem_gnt,
    output logic [ADDR_W-1:0]            mem_addr,
    input  logic                         mem_rvalid,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         wr_en,
    output logic [LINE_AW-1:0]           wr_line,
    output logic [LINE_WORDS*DATA_W-1:0] wr_data
);
    localparam int                LOFF_W    = ADDR_W - LINE_AW;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    fb_state_t             state_q;
    logic [LINE_AW-1:0]    line_q;
    logic [LINE_WORDS-1:0] wvalid_q;
    logic [WSEL_W-1:0]     beat_q;
    logic [DATA_W-1:0]     words_q [LINE_WORDS];

    // Sequencer: starts a fill, waits for grant, counts beats, installs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FB_IDLE;
            line_q   <= '0;
            wvalid_q <= '0;
            beat_q   <= '0;
        end else begin
            case (state_q)
                FB_IDLE: if (need_fill) begin
                    line_q   <= lk_line;
                    wvalid_q <= '0;
                    beat_q   <= '0;
                    state_q  <= FB_REQ;
                end
                FB_REQ: if (mem_gnt) state_q <= FB_FILL;
                FB_FILL: if (mem_rvalid) begin
                    wvalid_q[beat_q] <= 1'b1;
                    beat_q           <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) state_q <= FB_WRITE;
                end
                default: state_q <= FB_IDLE;
            endcase
        end
    end

    // Beat capture: stores each returning word in its slot.
    always_ff @(posedge clk) begin
        if (state_q == FB_FILL && mem_rvalid) words_q[beat_q] <= mem_rdata;
    end

    // Buffer lookup: same line and the requested word already arrived.
    always_comb begin
        fb_hit  = (line_q == lk_line) && wvalid_q[lk_wsel];
        fb_data = words_q[lk_wsel];
    end

    // Memory side and array install controls.
    always_comb begin
        busy     = (state_q != FB_IDLE);
        mem_req  = (state_q == FB_REQ);
        mem_addr = {line_q, {LOFF_W{1'b0}}};
        wr_en    = (state_q == FB_WRITE);
        wr_line  = line_q;
    end

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_pack
        assign wr_data[w*DATA_W +: DATA_W] = words_q[w];
    end

    // Request and address stay put until granted (R5).
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
    // Word flags fill contiguously from word 0 (R5).
    p_ascending_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid_q & (wvalid_q + 1'b1)) == '0);
    // Only a fully present line is installed (R3).
    p_whole_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> &wvalid_q);
endmodule

// File: rtl/icache_top.sv
// Module: direct-mapped instruction cache top.
// Splits the fetch address, runs the array and fill-buffer lookups in
// parallel, and acknowledges a hit combinationally in the request cycle.
// Assumes: the fetch side holds fetch_req and fetch_addr until fetch_ack;
// fetches are always whole 32-bit words.
module icache_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINES      = 64,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ack,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BOFF_W  = $clog2(DATA_W / 8);
    localparam int WSEL_W  = $clog2(LINE_WORDS);
    localparam int LOFF_W  = BOFF_W + WSEL_W;
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - IDX_W - LOFF_W;
    localparam int LINE_AW = ADDR_W - LOFF_W;

    logic [IDX_W-1:0]             lk_idx;
    logic [TAG_W-1:0]             lk_tag;
    logic [WSEL_W-1:0]            lk_wsel;
    logic [LINE_AW-1:0]           lk_line;
    logic                         unused_byte_off;
    logic                         tag_hit, array_hit, fb_hit, need_fill, busy;
    logic [DATA_W-1:0]            arr_data, fb_data;
    logic                         wr_en;
    logic [LINE_AW-1:0]           wr_line;
    logic [LINE_WORDS*DATA_W-1:0] wr_data;

    // Address split: word select, line index, tag, full line address.
    always_comb begin
        lk_wsel         = fetch_addr[BOFF_W +: WSEL_W];
        lk_idx          = fetch_addr[LOFF_W +: IDX_W];
        lk_tag          = fetch_addr[ADDR_W-1 -: TAG_W];
        lk_line         = fetch_addr[ADDR_W-1 : LOFF_W];
        unused_byte_off = ^fetch_addr[BOFF_W-1:0];
    end

    icache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .tag_hit(tag_hit),
        .wr_en(wr_en), .wr_idx(wr_line[IDX_W-1:0]),
        .wr_tag(wr_line[LINE_AW-1 -: TAG_W])
    );

    icache_data #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
                  .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
        .clk(clk),
        .rd_idx(lk_idx), .rd_wsel(lk_wsel), .rd_data(arr_data),
        .wr_en(wr_en), .wr_idx(wr_line[IDX_W-1:0]), .wr_line(wr_data)
    );

    icache_fill #(.ADDR_W(ADDR_W), .LINE_AW(LINE_AW), .WSEL_W(WSEL_W),
                  .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .need_fill(need_fill), .lk_line(lk_line), .lk_wsel(lk_wsel),
        .fb_hit(fb_hit), .fb_data(fb_data), .busy(busy),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data)
    );

    // Hit merge: the array counts only when enabled; the buffer wins on overlap.
    always_comb begin
        array_hit  = cache_en && tag_hit;
        fetch_ack  = fetch_req && (fb_hit || array_hit);
        fetch_data = fb_hit ? fb_data : arr_data;
        need_fill  = fetch_req && !fb_hit && !array_hit;
    end

    // A disabled array never acknowledges; only the buffer can (R8).
    p_disabled_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack && !cache_en |-> fb_hit);
    // A miss pending while a fill is busy leaves no burst open past the fill (R7).
    p_stall_no_new_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !$past(mem_req) || !$past(mem_gnt));
endmodule

// File: tb/sim_icache_top.sv
`timescale 1ns/1ps
module sim_icache_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cache_en;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic        mem_gnt;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int n_chk = 0, n_bad = 0;
    int burst_cnt = 0, beats_done = 0, overlap = 0;
    int gnt_dly = 1, beat_gap = 0;
    logic busy_m = 1'b0;
    logic [31:0] last_burst = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    icache_top u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mdl(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC0DE_5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: grants after gnt_dly, returns four ascending beats.
    initial begin
        mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0; mem_rvalid = 1'b0;
            if (rst_n === 1'b1 && mem_req) begin
                logic [31:0] base;
                base = mem_addr;
                burst_cnt++;
                last_burst = base;
                repeat (gnt_dly) @(negedge clk);
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                busy_m = 1'b1;
                beats_done = 0;
                for (int b = 0; b < 4; b++) begin
                    repeat (beat_gap) @(negedge clk);
                    mem_rvalid = 1'b1;
                    mem_rdata  = mdl(base + 32'(4 * b));
                    beats_done = b + 1;
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                end
                busy_m = 1'b0;
            end
        end
    end

    // Overlap monitor: no new request while a burst is still returning (R7).
    initial forever begin
        @(posedge clk); #2;
        if (mem_req && busy_m) overlap++;
    end

    // One fetch: hold the request until acknowledged, report stall cycles.
    task automatic do_fetch(input logic [31:0] a, output logic [31:0] d, output int waited, output int beats_at_ack);
        bit got;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; waited = 0; got = 0; d = '0; beats_at_ack = 0;
        while (!got && waited < 300) begin
            #1;
            if (fetch_ack) begin
                got = 1; d = fetch_data; beats_at_ack = beats_done;
            end else begin
                @(negedge clk);
                waited++;
            end
        end
        @(posedge clk); #1;
        fetch_req = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_m) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    localparam logic [31:0] A = 32'h0000_1040, B = 32'h0000_2080, C = 32'h0003_30C0;
    localparam logic [31:0] D = 32'h0004_4100, E = 32'h0005_5140, F = 32'h0006_6180;
    localparam logic [31:0] X = 32'h0000_0450, Y = 32'h0000_0850;

    task automatic t_reset();
        rst_n = 1'b0; cache_en = 1'b1; fetch_req = 1'b0; fetch_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(mem_req == 1'b0, "R1 mem_req idle after reset", 32'(mem_req), 32'd0);
        fetch_req = 1'b1; fetch_addr = B; #1;
        chk(fetch_ack == 1'b0, "R1 first fetch not acked", 32'(fetch_ack), 32'd0);
        fetch_req = 1'b0;
    endtask

    task automatic t_cold_fill();
        logic [31:0] d; int w, bt;
        int n0 = burst_cnt;
        beat_gap = 0;
        do_fetch(B, d, w, bt);
        chk(w > 0, "R5 cold miss stalls", 32'(w), 32'd1);
        chk(burst_cnt == n0 + 1 && last_burst == B, "R5 burst to line address", last_burst, B);
        chk(d == mdl(B), "R5 miss data", d, mdl(B));
        wait_idle();
        for (int k = 0; k < 4; k++) begin
            do_fetch(B + 32'(4 * k) + 32'(k), d, w, bt);
            chk(w == 0 && d == mdl(B + 32'(4 * k)), "R2 array hit word select", d, mdl(B + 32'(4 * k)));
        end
    endtask

    task automatic t_array_after_move();
        logic [31:0] d; int w, bt;
        do_fetch(A, d, w, bt);
        wait_idle();
        do_fetch(B + 32'd8, d, w, bt);
        chk(w == 0 && d == mdl(B + 32'd8), "R3 installed line hits from array", 32'(w), 32'd0);
    endtask

    task automatic t_early_buffer();
        logic [31:0] d; int w, bt;
        beat_gap = 3;
        do_fetch(C + 32'd8, d, w, bt);
        chk(d == mdl(C + 32'd8), "R4 critical word data", d, mdl(C + 32'd8));
        chk(bt == 3, "R5 word 2 arrives as third beat", 32'(bt), 32'd3);
        do_fetch(C + 32'd4, d, w, bt);
        chk(w == 0 && bt < 4, "R4 buffered word served before line completes", 32'(bt), 32'd3);
        chk(d == mdl(C + 32'd4), "R4 buffered word data", d, mdl(C + 32'd4));
        wait_idle();
    endtask

    task automatic t_nonblocking();
        logic [31:0] d; int w, bt;
        beat_gap = 3;
        do_fetch(D, d, w, bt);
        do_fetch(B + 32'd4, d, w, bt);
        chk(w == 0 && busy_m, "R6 array hit during burst", 32'(w), 32'd0);
        chk(d == mdl(B + 32'd4), "R6 array hit data", d, mdl(B + 32'd4));
        wait_idle();
    endtask

    task automatic t_stall();
        logic [31:0] d; int w, bt;
        int n0;
        beat_gap = 3;
        do_fetch(E, d, w, bt);
        n0 = burst_cnt;
        do_fetch(F + 32'd4, d, w, bt);
        chk(burst_cnt == n0 + 1 && last_burst == F, "R7 second burst after fill", last_burst, F);
        chk(overlap == 0, "R7 no request during fill", 32'(overlap), 32'd0);
        chk(d == mdl(F + 32'd4), "R7 stalled fetch data", d, mdl(F + 32'd4));
        wait_idle();
        do_fetch(E + 32'd12, d, w, bt);
        chk(w == 0 && d == mdl(E + 32'd12), "R7 first line was installed", 32'(w), 32'd0);
    endtask

    task automatic t_enable();
        logic [31:0] d; int w, bt;
        int n0 = burst_cnt;
        beat_gap = 0;
        cache_en = 1'b0;
        do_fetch(B, d, w, bt);
        chk(w > 0 && burst_cnt == n0 + 1, "R8 disabled array misses", 32'(burst_cnt - n0), 32'd1);
        wait_idle();
        do_fetch(B + 32'd12, d, w, bt);
        chk(w == 0 && d == mdl(B + 32'd12), "R8 buffer hit while disabled", 32'(w), 32'd0);
        cache_en = 1'b1;
        do_fetch(E + 32'd4, d, w, bt);
        chk(w == 0 && d == mdl(E + 32'd4), "R8 array hits again when enabled", 32'(w), 32'd0);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int w, bt;
        int n0;
        beat_gap = 0;
        do_fetch(X, d, w, bt); wait_idle();
        do_fetch(Y, d, w, bt); wait_idle();
        n0 = burst_cnt;
        do_fetch(X, d, w, bt);
        chk(w > 0 && burst_cnt == n0 + 1, "R9 evicted line misses", 32'(burst_cnt - n0), 32'd1);
        chk(d == mdl(X), "R9 refetched data", d, mdl(X));
        wait_idle();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cold_fill();
        t_array_after_move();
        t_early_buffer();
        t_nonblocking();
        t_stall();
        t_enable();
        t_conflict();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule